// File: doc/BRIEF.md
# Serial Write-Only Command/Data Byte Receiver

This block is the receive side of a four-wire serial link into a display controller. It accepts a serial clock, a serial data line, a command/data select line and a pair of chip-select pins. It builds 8-bit tokens from the data line, most significant bit first, with one bit on each rising serial-clock edge. Each finished token leaves on one of two strobed byte outputs: one carries command bytes and the other carries display-memory data bytes.

All external pins pass through two-flop synchronizers into the system clock. Serial-clock edges are then detected in that domain, so the system clock must run at least four times faster than the serial clock. The link only carries writes. Deselecting the device in the middle of a byte throws away the bits gathered so far. The command/data line is not read at the start of a token. It is taken from the low phase of the serial clock just before the token's last bit is latched.

Top module: `serial_token_rx`

## Requirements
- R1: While reset is active and after it is released, both strobes are low and both byte outputs are 0x00.
- R2: A token is 8 bits wide. Its first bit is bit 7 and its last is bit 0, and each bit is taken on a rising serial-clock edge while the device is selected.
- R3: The token type comes from the command/data line as it stands during the low serial-clock phase before the eighth rising edge. Values present during the earlier bits, and changes that arrive together with the eighth rising edge, have no effect.
- R4: A type value of 0 sends the byte out as a command: the command byte output changes and the command strobe pulses. A type value of 1 does the same on the data output and data strobe. A byte output keeps its value until the next token of its own type.
- R5: Each finished token gives exactly one strobe pulse, one system clock long. The two strobes are never high in the same cycle.
- R6: The device is selected only when select-0 is low and select-1 is high. Under any other combination, serial-clock edges produce no output and collect no bits.
- R7: Leaving the selected state clears the partial bit count, so the next token starts again at bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel0_i | input | 1 | Select pin 0, active low |
| sel1_i | input | 1 | Select pin 1, active high |
| sck_i | input | 1 | Serial clock; bits latch on its rising edge |
| sdi_i | input | 1 | Serial data in, MSB first |
| cd_i | input | 1 | Token type: 0 command, 1 display data |
| cmd_valid_o | output | 1 | One-cycle strobe for a command byte |
| cmd_byte_o | output | 8 | Last command byte received |
| data_valid_o | output | 1 | One-cycle strobe for a data byte |
| data_byte_o | output | 8 | Last display data byte received |

## Verification
The hardest case to reach from the ports is a type line that changes inside a token. It takes the wrong value on bits 7 to 1, the right value only in the low phase before the last edge, and flips again on the very edge that latches bit 0. The driver task builds this pattern into every token, with both polarities, so any sampling point other than the final low phase sends the byte to the wrong strobe. Aborted bytes are driven by dropping the select after three and after seven bits and then sending a full token. This shows that stale bits do not shift into the next byte.

// File: rtl/srx_pkg.sv
package srx_pkg;
    localparam int unsigned TOKEN_W     = 8;
    localparam int unsigned SYNC_STAGES = 2;
    localparam int unsigned PIN_W       = 5;

    // bit positions inside the synchronized pin vector
    localparam int unsigned PIN_SCK  = 0;
    localparam int unsigned PIN_SDI  = 1;
    localparam int unsigned PIN_CD   = 2;
    localparam int unsigned PIN_SEL0 = 3;
    localparam int unsigned PIN_SEL1 = 4;

    // reset value: select-0 high, everything else low (deselected, clock idle)
    localparam logic [PIN_W-1:0] PIN_RST = PIN_W'(1) << PIN_SEL0;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int unsigned WIDTH  = 5,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
        end else begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= stage_d[s];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/srx_assembler.sv
module srx_assembler #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel_i,
    input  logic         sck_i,
    input  logic         sdi_i,
    input  logic         cd_i,
    output logic         cmd_valid_o,
    output logic [W-1:0] cmd_byte_o,
    output logic         data_valid_o,
    output logic [W-1:0] data_byte_o,
    output logic [$clog2(W)-1:0] bit_cnt_o
);
    localparam int unsigned CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    typedef struct packed {
        logic [W-1:0]     shreg;
        logic [CNT_W-1:0] cnt;
        logic             cd_flag;
        logic             sck_prev;
        logic             cmd_valid;
        logic [W-1:0]     cmd_byte;
        logic             data_valid;
        logic [W-1:0]     data_byte;
    } asm_state_t;

    asm_state_t st_d, st_q;
    logic       rise;
    logic [W-1:0] assembled;

    always_comb begin
        st_d            = st_q;
        st_d.cmd_valid  = 1'b0;
        st_d.data_valid = 1'b0;
        st_d.sck_prev   = sck_i;
        rise            = sck_i & ~st_q.sck_prev;
        assembled       = {st_q.shreg[W-2:0], sdi_i};
        if (!sel_i) begin
            st_d.cnt = '0;
        end else begin
            // type is tracked only during the low phase ahead of the last bit
            if (!sck_i && st_q.cnt == LAST) begin
                st_d.cd_flag = cd_i;
            end
            if (rise) begin
                st_d.shreg = assembled;
                if (st_q.cnt == LAST) begin
                    st_d.cnt = '0;
                    if (st_q.cd_flag) begin
                        st_d.data_valid = 1'b1;
                        st_d.data_byte  = assembled;
                    end else begin
                        st_d.cmd_valid = 1'b1;
                        st_d.cmd_byte  = assembled;
                    end
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_valid_o  = st_q.cmd_valid;
    assign cmd_byte_o   = st_q.cmd_byte;
    assign data_valid_o = st_q.data_valid;
    assign data_byte_o  = st_q.data_byte;
    assign bit_cnt_o    = st_q.cnt;
endmodule

// File: rtl/serial_token_rx.sv
module serial_token_rx
    import srx_pkg::*;
#(
    parameter int unsigned TW = TOKEN_W,
    parameter int unsigned SYNC_N = SYNC_STAGES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel0_i,
    input  logic          sel1_i,
    input  logic          sck_i,
    input  logic          sdi_i,
    input  logic          cd_i,
    output logic          cmd_valid_o,
    output logic [TW-1:0] cmd_byte_o,
    output logic          data_valid_o,
    output logic [TW-1:0] data_byte_o
);
    localparam int unsigned CNT_W = $clog2(TW);

    logic [PIN_W-1:0] pins_raw;
    logic [PIN_W-1:0] pins_s;
    logic             sel_s;
    logic [CNT_W-1:0] bit_cnt;

    always_comb begin
        pins_raw           = '0;
        pins_raw[PIN_SCK]  = sck_i;
        pins_raw[PIN_SDI]  = sdi_i;
        pins_raw[PIN_CD]   = cd_i;
        pins_raw[PIN_SEL0] = sel0_i;
        pins_raw[PIN_SEL1] = sel1_i;
    end

    srx_sync #(
        .WIDTH  (PIN_W),
        .STAGES (SYNC_N),
        .RST_VAL(PIN_RST)
    ) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pins_raw),
        .sync_o (pins_s)
    );

    assign sel_s = ~pins_s[PIN_SEL0] & pins_s[PIN_SEL1];

    srx_assembler #(.W(TW)) asm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_i       (sel_s),
        .sck_i       (pins_s[PIN_SCK]),
        .sdi_i       (pins_s[PIN_SDI]),
        .cd_i        (pins_s[PIN_CD]),
        .cmd_valid_o (cmd_valid_o),
        .cmd_byte_o  (cmd_byte_o),
        .data_valid_o(data_valid_o),
        .data_byte_o (data_byte_o),
        .bit_cnt_o   (bit_cnt)
    );
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cmd_valid_o,
    input logic [W-1:0] cmd_byte_o,
    input logic         data_valid_o,
    input logic [W-1:0] data_byte_o,
    input logic         sel_s,
    input logic [$clog2(W)-1:0] bit_cnt
);
    AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid_o && data_valid_o)); // R5
    AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o); // R5
    AST_DATA_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid_o |=> !data_valid_o); // R5
    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd_byte_o) |-> cmd_valid_o); // R4
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_byte_o) |-> data_valid_o); // R4
    AST_DESEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_s |=> (bit_cnt == '0)); // R7
    AST_OUT_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o || data_valid_o) |-> $past(sel_s)); // R6
endmodule

bind serial_token_rx srx_checker #(.W(TW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid_o (cmd_valid_o),
    .cmd_byte_o  (cmd_byte_o),
    .data_valid_o(data_valid_o),
    .data_byte_o (data_byte_o),
    .sel_s       (sel_s),
    .bit_cnt     (bit_cnt)
);

// File: tb/serial_token_rx_tb_top.sv
module serial_token_rx_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel0 = 1'b1, sel1 = 1'b0, sck = 1'b0, sdi = 1'b0, cd = 1'b0;
    logic       cmd_valid, data_valid;
    logic [7:0] cmd_byte, data_byte;

    int tests = 0;
    int fails = 0;

    typedef struct {
        logic [7:0] b;
        logic       is_data;
        string      req;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    serial_token_rx dut_i (
        .clk(clk), .rst_n(rst_n), .sel0_i(sel0), .sel1_i(sel1),
        .sck_i(sck), .sdi_i(sdi), .cd_i(cd),
        .cmd_valid_o(cmd_valid), .cmd_byte_o(cmd_byte),
        .data_valid_o(data_valid), .data_byte_o(data_byte)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one bit: drive in low phase, rise, fall. cd_low applies in the low phase,
    // cd_rise is driven together with the rising edge.
    task automatic send_bit(input logic b, input logic cd_low, input logic cd_rise);
        sdi = b; cd = cd_low;
        wait_clk(4);
        sck = 1'b1; cd = cd_rise;
        wait_clk(4);
        sck = 1'b0;
    endtask

    // full token; type line is wrong on bits 7..1 and flips at the last edge (R3)
    task automatic send_token(input logic [7:0] b, input logic kind, input bit expect_out, input string req);
        if (expect_out) exp_q.push_back('{b, kind, req});
        for (int i = 7; i >= 1; i--) send_bit(b[i], ~kind, ~kind);
        send_bit(b[0], kind, ~kind);
        wait_clk(4);
    endtask

    task automatic select(input logic s0, input logic s1);
        sel0 = s0; sel1 = s1;
        wait_clk(4);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_valid && data_valid)
                check(1'b0, "R5 both strobes", 3, 1);
            else if (cmd_valid || data_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected byte", cmd_valid ? int'(cmd_byte) : int'(data_byte), 0);
                end else begin
                    exp_t e;
                    logic [7:0] got;
                    e = exp_q.pop_front();
                    got = data_valid ? data_byte : cmd_byte;
                    check(got == e.b && data_valid == e.is_data, e.req,
                          {23'd0, data_valid, got}, {23'd0, e.is_data, e.b});
                end
            end
        end
    end

    bit done = 1'b0;
    initial begin
        wait_clk(200000);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        wait_clk(3);
        // R1: reset state, during and after reset
        check(!cmd_valid && !data_valid, "R1 strobes in reset", {cmd_valid, data_valid}, 0);
        rst_n = 1'b1;
        wait_clk(3);
        check(cmd_byte == 8'h00, "R1 cmd byte", cmd_byte, 0);
        check(data_byte == 8'h00, "R1 data byte", data_byte, 0);

        select(1'b0, 1'b1);
        // R2/R4: mixed tokens, MSB first
        send_token(8'hA5, 1'b0, 1'b1, "R2 cmd A5");
        send_token(8'h3C, 1'b1, 1'b1, "R4 data 3C");
        send_token(8'h80, 1'b0, 1'b1, "R2 cmd 80");
        send_token(8'h01, 1'b1, 1'b1, "R2 data 01");
        send_token(8'hFF, 1'b1, 1'b1, "R3 data FF");
        send_token(8'h00, 1'b0, 1'b1, "R3 cmd 00");
        // R4: command output held across a data token
        send_token(8'h5E, 1'b1, 1'b1, "R4 data 5E");
        check(cmd_byte == 8'h00, "R4 cmd byte held", cmd_byte, 8'h00);
        check(data_byte == 8'h5E, "R4 data byte held", data_byte, 8'h5E);

        // R6: bad select combinations ignore traffic
        select(1'b1, 1'b1);
        send_token(8'h77, 1'b0, 1'b0, "R6");
        select(1'b0, 1'b0);
        send_token(8'h66, 1'b1, 1'b0, "R6");
        select(1'b1, 1'b0);
        send_token(8'h55, 1'b0, 1'b0, "R6");
        check(cmd_byte == 8'h00, "R6 cmd untouched", cmd_byte, 8'h00);
        check(data_byte == 8'h5E, "R6 data untouched", data_byte, 8'h5E);
        select(1'b0, 1'b1);
        send_token(8'hC3, 1'b0, 1'b1, "R6 after reselect");

        // R7: abort after three bits, then after seven bits
        for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b0, 1'b0);
        select(1'b1, 1'b0);
        select(1'b0, 1'b1);
        send_token(8'h5A, 1'b1, 1'b1, "R7 abort 3 bits");
        for (int i = 0; i < 7; i++) send_bit(1'b0, 1'b0, 1'b0);
        select(1'b0, 1'b0);
        select(1'b0, 1'b1);
        send_token(8'h96, 1'b0, 1'b1, "R7 abort 7 bits");
        send_token(8'h69, 1'b1, 1'b1, "R2 data 69");

        wait_clk(10);
        check(exp_q.size() == 0, "R5 all tokens seen", exp_q.size(), 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule